// File: doc/BRIEF.md
# Prescaled Timer With Selectable Count Source

This block is an 8-bit up-counter that ticks from one of two sources. The first is the system clock, which gives a tick on every cycle. The second is an external count pin, which is first passed through a synchroniser and then an edge detector that can pick either the rising or the falling edge. A power-of-two prescaler can sit between the source and the counter and divide the ticks by 2 up to 256. The prescaler can also be handed to a watchdog path. In that case the counter sees every source tick undivided, and the prescaler's divided output is brought out on a separate pin for that path.

When the counter wraps from its all-ones value, a sticky overflow flag is set. An interrupt request is raised while the flag is set and the interrupt enable is on. Software reaches the block through a single address/data port. A write has effect on the rising clock edge. A read returns the selected register combinationally. Writing the counter restarts the prescaler and holds the count still for two cycles, so a freshly loaded value is seen before counting resumes.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the counter reads 0x00, the configuration register reads 0x3F, and the control register reads 0x00 with `irq` low.
- R2: Register map: address 0 is the counter, address 1 is the configuration and address 2 is the control; address 3 reads 0x00. Configuration bits: [2:0] ratio code, [3] prescaler to watchdog, [4] falling-edge select, [5] external source; bits [7:6] read as 0. Control bits: [0] overflow flag, [1] interrupt enable.
- R3: With the internal source and the prescaler on the timer (bit 3 = 0), ratio code n makes the counter advance once every 2^(n+1) clock cycles.
- R4: With bit 3 = 1, the counter advances on every source tick. `wd_div_tick` then pulses once every 2^(n+1) cycles, and it stays low while bit 3 = 0.
- R5: With the external source, a pin transition that precedes clock edge 1 changes the count after edge 3 and not before. Bit 4 = 0 counts low-to-high transitions only, and bit 4 = 1 counts high-to-low transitions only.
- R6: An increment from 0xFF wraps the counter to 0x00 and sets the overflow flag on the same edge.
- R7: The overflow flag stays set until a control write with bit 0 = 0. If that write falls on the same edge as an overflow, the flag stays set.
- R8: `irq` is high exactly when the overflow flag and the interrupt enable are both 1.
- R9: A counter write loads the value, clears the prescaler and blocks increments on the next two edges. Counting then restarts with a full prescale period whatever the earlier phase was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; internal source ticks once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| ext_pin | input | 1 | Asynchronous external count pin |
| irq | output | 1 | Overflow interrupt request |
| ovf_flag | output | 1 | Sticky overflow flag |
| wd_div_tick | output | 1 | Divided prescaler tick when the prescaler is assigned to the watchdog path |

## Verification
Two events can fall on the same edge. One is the hardware overflow setting the flag. The other is a software control write clearing the flag. The bench loads the counter with 0xFD in undivided internal mode and counts edges through the two-cycle hold, so that the clearing write lands on exactly the edge where the count wraps. The flag must read 1 afterwards, and `irq` must follow the enable value written on that same edge. A second clear on a quiet edge must then drop the flag, which shows that the first one was overridden and not ignored.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int RATIO_W = 3;
  localparam int CFG_W   = RATIO_W + 3;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CFG   = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;

  // packed layout: [5] src_ext, [4] edge_fall, [3] psc_to_wd, [2:0] ratio
  typedef struct packed {
    logic               src_ext;
    logic               edge_fall;
    logic               psc_to_wd;
    logic [RATIO_W-1:0] ratio;
  } cfg_t;

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_fall,
  output logic tick
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              settled;

  assign settled = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= settled;
    end
  end

  always_comb begin
    if (edge_fall) tick = prev_q & ~settled;
    else           tick = ~prev_q & settled;
  end

  // R5: a single transition gives a single-cycle tick
  assert_single_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || !$stable(edge_fall)));

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int W       = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               in_tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               div_tick
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] mask;

  // low (code+1) bits set: divide by 2^(code+1)
  function automatic logic [W-1:0] ratio_mask(input logic [RATIO_W-1:0] code);
    logic [W:0] full;
    full = ({{W{1'b0}}, 1'b1} << (32'(code) + 32'd1)) - {{W{1'b0}}, 1'b1};
    return full[W-1:0];
  endfunction

  assign mask     = ratio_mask(ratio);
  assign div_tick = in_tick && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (in_tick) cnt_q <= cnt_q + W'(1);
  end

  // R9: a cleared prescaler never releases a tick on the next cycle
  assert_clear_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !div_tick);

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_pin,
  output logic       irq,
  output logic       ovf_flag,
  output logic       wd_div_tick
);
  import ptmr_pkg::*;

  localparam int INH_W = $clog2(INHIBIT + 1);

  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [INH_W-1:0] inh_q;
  logic             flag_q;
  logic             ien_q;

  logic wr_count, wr_cfg, wr_ctrl;
  logic ext_tick, src_tick, run, inh_active;
  logic psc_in, psc_div, timer_inc, ovf_event;

  assign wr_count = wr_en && (addr == ADDR_COUNT);
  assign wr_cfg   = wr_en && (addr == ADDR_CFG);
  assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);

  ptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (ext_pin),
    .edge_fall (cfg_q.edge_fall),
    .tick      (ext_tick)
  );

  assign src_tick   = cfg_q.src_ext ? ext_tick : 1'b1;
  assign inh_active = (inh_q != '0);
  assign run        = !inh_active && !wr_count;
  assign psc_in     = run && (cfg_q.psc_to_wd ? 1'b1 : src_tick);

  ptmr_prescaler #(.W(PSC_W), .RATIO_W(RATIO_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (wr_count),
    .in_tick  (psc_in),
    .ratio    (cfg_q.ratio),
    .div_tick (psc_div)
  );

  assign timer_inc   = run && (cfg_q.psc_to_wd ? src_tick : psc_div);
  assign ovf_event   = timer_inc && (cnt_q == '1);
  assign wd_div_tick = cfg_q.psc_to_wd && psc_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= cfg_t'({CFG_W{1'b1}});
    end else if (wr_cfg) begin
      cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inh_q <= '0;
    end else if (wr_count) begin
      cnt_q <= wr_data[CNT_W-1:0];
      inh_q <= INH_W'(INHIBIT);
    end else begin
      if (inh_active) inh_q <= inh_q - INH_W'(1);
      if (timer_inc)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ien_q <= wr_data[1];
      if (ovf_event)    flag_q <= 1'b1;
      else if (wr_ctrl) flag_q <= wr_data[0];
    end
  end

  assign ovf_flag = flag_q;
  assign irq      = flag_q && ien_q;

  always_comb begin
    unique case (addr)
      ADDR_COUNT: rd_data = 8'(cnt_q);
      ADDR_CFG:   rd_data = 8'(cfg_q);
      ADDR_CTRL:  rd_data = {6'd0, ien_q, flag_q};
      default:    rd_data = 8'd0;
    endcase
  end

  // R6: wrap sets the flag and lands on zero
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> (ovf_flag && cnt_q == '0));

  // R7: flag holds unless a clearing control write arrives
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_ctrl && !wr_data[0])) |=> ovf_flag);

  // R7: flag only rises from an overflow or a software set
  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ovf_event || (wr_ctrl && wr_data[0])));

  // R9: the count is frozen during the post-write hold
  assert_hold_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_active && !wr_count) |=> $stable(cnt_q));

  // R3: without a load the count moves by at most one per cycle
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       ext_pin = 1'b0;
  logic       irq, ovf_flag, wd_div_tick;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prescaled_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_pin(ext_pin), .irq(irq), .ovf_flag(ovf_flag),
    .wd_div_tick(wd_div_tick)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int pulses;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);

    // R1 reset values
    rd(2'd0, v); chk("R1 count", v, 8'h00);
    rd(2'd1, v); chk("R1 cfg", v, 8'h3F);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", irq, 0);

    // R2 map: config readback masks upper bits, address 3 is zero
    wr(2'd1, 8'hD5);
    rd(2'd1, v); chk("R2 cfg readback", v, 8'h15);
    rd(2'd3, v); chk("R2 addr3", v, 8'h00);

    // R3 sweep over every ratio code, internal source, prescaler on timer
    for (int n = 0; n < 8; n++) begin
      int p;
      p = 1 << (n + 1);
      wr(2'd1, 8'(n));
      wr(2'd0, 8'h00);
      cycles(2 + 3 * p - 1);
      rd(2'd0, v); chk($sformatf("R3 code %0d before boundary", n), v, 2);
      cycles(1);
      rd(2'd0, v); chk($sformatf("R3 code %0d at boundary", n), v, 3);
    end

    // R4 watchdog assignment: undivided counting plus divided side output
    wr(2'd1, 8'h0A);
    wr(2'd0, 8'h00);
    cycles(20);
    rd(2'd0, v); chk("R4 undivided count", v, 18);
    pulses = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (wd_div_tick) pulses++;
    end
    chk("R4 wd pulses in 32 cycles", pulses, 4);
    wr(2'd1, 8'h02);
    pulses = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (wd_div_tick) pulses++;
    end
    chk("R4 wd quiet when on timer", pulses, 0);

    // R5 external rising edge, undivided, latency
    wr(2'd1, 8'h28);
    wr(2'd0, 8'h00);
    cycles(4);
    ext_pin = 1'b1;
    cycles(2);
    rd(2'd0, v); chk("R5 no change after edge 2", v, 0);
    cycles(1);
    rd(2'd0, v); chk("R5 change after edge 3", v, 1);
    ext_pin = 1'b0;
    cycles(5);
    rd(2'd0, v); chk("R5 falling ignored in rising mode", v, 1);
    for (int i = 0; i < 3; i++) begin
      ext_pin = 1'b1; cycles(4);
      ext_pin = 1'b0; cycles(4);
    end
    rd(2'd0, v); chk("R5 rising count", v, 4);

    // R5 falling edge mode
    wr(2'd1, 8'h38);
    wr(2'd0, 8'h00);
    cycles(3);
    ext_pin = 1'b1; cycles(5);
    rd(2'd0, v); chk("R5 rising ignored in falling mode", v, 0);
    ext_pin = 1'b0; cycles(5);
    rd(2'd0, v); chk("R5 falling counted", v, 1);
    for (int i = 0; i < 2; i++) begin
      ext_pin = 1'b1; cycles(4);
      ext_pin = 1'b0; cycles(4);
    end
    rd(2'd0, v); chk("R5 falling count", v, 3);

    // R5 external source through the 1:2 prescaler
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h00);
    cycles(3);
    for (int i = 0; i < 4; i++) begin
      ext_pin = 1'b1; cycles(4);
      ext_pin = 1'b0; cycles(4);
    end
    rd(2'd0, v); chk("R5 external divided by 2", v, 2);

    // R6/R8 wrap and interrupt
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'hFD);
    cycles(4);
    rd(2'd0, v); chk("R6 count before wrap", v, 8'hFF);
    chk("R6 flag before wrap", ovf_flag, 0);
    cycles(1);
    rd(2'd0, v); chk("R6 count wrapped", v, 8'h00);
    chk("R6 flag set", ovf_flag, 1);
    chk("R8 irq with enable", irq, 1);
    cycles(10);
    chk("R7 flag sticky", ovf_flag, 1);
    wr(2'd2, 8'h02);
    chk("R7 flag cleared", ovf_flag, 0);
    chk("R8 irq after clear", irq, 0);

    // R7 clear on the overflow edge: overflow wins; R8 enable off masks irq
    wr(2'd0, 8'hFD);
    cycles(4);
    wr(2'd2, 8'h00);
    chk("R7 coincident clear loses", ovf_flag, 1);
    chk("R8 irq masked by enable", irq, 0);
    rd(2'd2, v); chk("R2 ctrl readback", v, 8'h01);
    wr(2'd2, 8'h00);
    chk("R7 quiet clear", ovf_flag, 0);

    // R9 load restarts prescaler at two different phases
    for (int ph = 6; ph < 8; ph++) begin
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h00);
      cycles(ph);
      wr(2'd0, 8'h10);
      cycles(2);
      rd(2'd0, v); chk($sformatf("R9 hold phase %0d", ph), v, 8'h10);
      cycles(3);
      rd(2'd0, v); chk($sformatf("R9 before period phase %0d", ph), v, 8'h10);
      cycles(1);
      rd(2'd0, v); chk($sformatf("R9 full period phase %0d", ph), v, 8'h11);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule